// File: doc/BRIEF.md
# FIFO Watermark Status and Interrupt Unit

This block watches the fill levels of a serial port's transmit and receive FIFOs and turns them into a status word, one interrupt line and two DMA request lines. The FIFO memories and the shift engine stay outside. The block receives their level counts, the push and pop strobes aimed at each FIFO, and single-cycle pulses for frame completion and frame-sync faults. It returns the status word and a per-strobe "allowed" qualifier. The FIFO control logic uses that qualifier so that an illegal push or pop never changes stored data.

Software picks one of eight thresholds for each direction with a 3-bit code. The transmit request counts free stages and the receive request counts occupied stages. Empty, full and the two request bits track the levels as they change. Error and frame-end bits stay set until they are cleared by writing ones to them. An enable word selects which status bits drive the interrupt, and two extra enable bits gate the DMA requests.

Top module: `wmi_fifo_status`

## Requirements
- R1: The transmit code is taken from write data bits 31:29 on a watermark write (select 0). Codes 0..7 give a free-stage threshold of 64, 32, 24, 16, 12, 8, 4 or 1. Status bit 28 is 1 while (TX_DEPTH - tx_level) is at least that threshold.
- R2: The receive code is taken from write data bits 15:13 on the same write. Codes 0..7 give an occupied-stage threshold of 1, 4, 8, 16, 32, 64, 128 or 256. Status bit 12 is 1 while rx_level is at least that threshold.
- R3: Status bit 29 is 1 exactly when tx_level is 0. Status bit 13 is 1 exactly when rx_level equals RX_DEPTH. Both follow the levels in the same cycle.
- R4: A transmit push while tx_level equals TX_DEPTH sets bit 20, and a transmit pop while tx_level is 0 sets bit 19. A receive push while rx_level equals RX_DEPTH sets bit 3, and a receive pop while rx_level is 0 sets bit 4. Each bit is visible from the next cycle.
- R5: Each allowed output equals its strobe, except that it is 0 for a push while full or a pop while empty.
- R6: Pulses on tx_frame_end, tx_sync_err, rx_frame_end and rx_sync_err set bits 23, 21, 7 and 5, visible from the next cycle. These bits, like those of R4, hold until cleared.
- R7: A clear write (select 2) clears the bits of R4 and R6 at the positions where write data holds 1 and leaves the others alone. It does not affect bits 29, 28, 13 or 12. An event in the same cycle as its clear leaves the bit set.
- R8: An enable write (select 1) loads the enable word. irq is the OR, over the twelve status positions, of status AND enable.
- R9: tx_dma_req equals enable bit 31 AND status bit 28. rx_dma_req equals enable bit 15 AND status bit 12.
- R10: Synchronous reset clears the held status bits, the enable word and both codes to 0.
- R11: After an enable word of 0 is written, irq, tx_dma_req and rx_dma_req stay 0 whatever the status.
- R12: Status bits outside the twelve listed positions always read 0.
- R13: A write with select 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | $clog2(TX_DEPTH+1) | Occupied stages in the transmit FIFO |
| rx_level | input | $clog2(RX_DEPTH+1) | Occupied stages in the receive FIFO |
| tx_push | input | 1 | Write attempt into the transmit FIFO |
| tx_pop | input | 1 | Read attempt from the transmit FIFO by the shifter |
| rx_push | input | 1 | Write attempt into the receive FIFO by the shifter |
| rx_pop | input | 1 | Read attempt from the receive FIFO |
| tx_frame_end | input | 1 | Pulse: transmit frame finished |
| tx_sync_err | input | 1 | Pulse: transmit frame-sync fault |
| rx_frame_end | input | 1 | Pulse: receive frame finished |
| rx_sync_err | input | 1 | Pulse: receive frame-sync fault |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 watermark, 1 enable, 2 clear, 3 reserved |
| wr_data | input | 32 | Write data |
| status | output | 32 | Status word |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_push_ok | output | 1 | Transmit push may proceed |
| tx_pop_ok | output | 1 | Transmit pop may proceed |
| rx_push_ok | output | 1 | Receive push may proceed |
| rx_pop_ok | output | 1 | Receive pop may proceed |

## Verification
The bench drives levels at and one stage beside every threshold for all eight codes in both directions. A design with a reversed or shifted code table, or with `>` in place of `>=`, would then raise a request one stage early or late. It pushes into a full FIFO and pops an empty one. A design that counted only the strobe, or let the strobe through, would set flags at the wrong time or pass a corrupting access. It also collides an event with its own clear and writes back a status word just read. This catches a clear that wins over a set, and a clear that wrongly drops the level bits.

// File: rtl/wmi_pkg.sv
package wmi_pkg;

    localparam int REG_W = 32;

    // Watermark code fields in the watermark write word
    localparam int TX_CODE_LO = 29;
    localparam int RX_CODE_LO = 13;

    // Status / enable bit positions
    localparam int B_TX_DMA_EN = 31;
    localparam int B_TX_EMPTY  = 29;
    localparam int B_TX_REQ    = 28;
    localparam int B_TX_FEND   = 23;
    localparam int B_TX_SERR   = 21;
    localparam int B_TX_OVF    = 20;
    localparam int B_TX_UDF    = 19;
    localparam int B_RX_DMA_EN = 15;
    localparam int B_RX_FULL   = 13;
    localparam int B_RX_REQ    = 12;
    localparam int B_RX_FEND   = 7;
    localparam int B_RX_SERR   = 5;
    localparam int B_RX_UDF    = 4;
    localparam int B_RX_OVF    = 3;

    localparam int N_STICKY = 8;

    typedef enum logic [1:0] {
        SEL_WMARK  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_RSVD   = 2'd3
    } wsel_e;

    // Held events; bit index i maps to a status position via sticky_pos()
    typedef struct packed {
        logic tx_fend;
        logic tx_serr;
        logic tx_ovf;
        logic tx_udf;
        logic rx_fend;
        logic rx_serr;
        logic rx_udf;
        logic rx_ovf;
    } evt_t;

    typedef struct packed {
        logic [2:0] tx_code;
        logic [2:0] rx_code;
    } wmark_t;

    function automatic int sticky_pos(input int idx);
        case (idx)
            7:       return B_TX_FEND;
            6:       return B_TX_SERR;
            5:       return B_TX_OVF;
            4:       return B_TX_UDF;
            3:       return B_RX_FEND;
            2:       return B_RX_SERR;
            1:       return B_RX_UDF;
            default: return B_RX_OVF;
        endcase
    endfunction

    // Free stages needed for a transmit request
    function automatic logic [15:0] tx_stages(input logic [2:0] code);
        case (code)
            3'd0:    return 16'd64;
            3'd1:    return 16'd32;
            3'd2:    return 16'd24;
            3'd3:    return 16'd16;
            3'd4:    return 16'd12;
            3'd5:    return 16'd8;
            3'd6:    return 16'd4;
            default: return 16'd1;
        endcase
    endfunction

    // Occupied stages needed for a receive request: 1, then powers of two from 4
    function automatic logic [15:0] rx_stages(input logic [2:0] code);
        if (code == 3'd0)
            return 16'd1;
        return 16'd1 << (int'(code) + 1);
    endfunction

    function automatic logic [REG_W-1:0] src_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[B_TX_EMPTY] = 1'b1;
        m[B_TX_REQ]   = 1'b1;
        m[B_RX_FULL]  = 1'b1;
        m[B_RX_REQ]   = 1'b1;
        for (int i = 0; i < N_STICKY; i++)
            m[sticky_pos(i)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/wmi_thresh_cmp.sv
module wmi_thresh_cmp #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic [15:0]   stages,
    output logic          hit
);
    localparam int EW = (CW > 16) ? CW : 16;

    logic [EW-1:0] count_ext;
    logic [EW-1:0] stages_ext;

    assign count_ext  = EW'(count);
    assign stages_ext = EW'(stages);
    assign hit        = (count_ext >= stages_ext);

    // R1/R2: every decoded threshold is at least one stage
    a_r1_zero_never_hits: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !hit);

endmodule

// File: rtl/wmi_sticky_bank.sv
module wmi_sticky_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= (q & ~clr) | set;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r6_set_lands: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q[i]);
        a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !q[i]);
        a_r7_hold: assert property (@(posedge clk) disable iff (rst)
            (!clr[i] && !set[i]) |=> $stable(q[i]));
    end

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/wmi_irq_combine.sv
module wmi_irq_combine
    import wmi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] status,
    input  logic [REG_W-1:0] enable,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req
);
    localparam logic [REG_W-1:0] SRC_M = src_mask();

    assign irq        = |(status & enable & SRC_M);
    assign tx_dma_req = enable[B_TX_DMA_EN] & status[B_TX_REQ];
    assign rx_dma_req = enable[B_RX_DMA_EN] & status[B_RX_REQ];

    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> (!irq && !tx_dma_req && !rx_dma_req));
    a_r9_tx_dma_needs_req: assert property (@(posedge clk) disable iff (rst)
        tx_dma_req |-> status[B_TX_REQ]);
    a_r9_rx_dma_needs_req: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> status[B_RX_REQ]);

endmodule

// File: rtl/wmi_fifo_status.sv
module wmi_fifo_status
    import wmi_pkg::*;
#(
    parameter int TX_DEPTH = 64,
    parameter int RX_DEPTH = 256,
    localparam int TXLW = $clog2(TX_DEPTH + 1),
    localparam int RXLW = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TXLW-1:0]  tx_level,
    input  logic [RXLW-1:0]  rx_level,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             tx_frame_end,
    input  logic             tx_sync_err,
    input  logic             rx_frame_end,
    input  logic             rx_sync_err,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] status,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req,
    output logic             tx_push_ok,
    output logic             tx_pop_ok,
    output logic             rx_push_ok,
    output logic             rx_pop_ok
);
    localparam logic [TXLW-1:0] TX_FULL_LVL = TXLW'(TX_DEPTH);
    localparam logic [RXLW-1:0] RX_FULL_LVL = RXLW'(RX_DEPTH);

    wsel_e             sel;
    wmark_t            wm_q;
    logic [REG_W-1:0]  ier_q;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [TXLW-1:0]   tx_free;
    logic              tx_req, rx_req;
    evt_t              ev;
    logic [N_STICKY-1:0] clr_v;
    logic [N_STICKY-1:0] sticky_q;

    assign sel = wsel_e'(wr_sel);

    // Configuration: watermark codes and enable word
    always_ff @(posedge clk) begin
        if (rst) begin
            wm_q  <= '0;
            ier_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_WMARK: begin
                    wm_q.tx_code <= wr_data[TX_CODE_LO +: 3];
                    wm_q.rx_code <= wr_data[RX_CODE_LO +: 3];
                end
                SEL_ENABLE: ier_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Level conditions
    assign tx_empty = (tx_level == '0);
    assign tx_full  = (tx_level == TX_FULL_LVL);
    assign rx_empty = (rx_level == '0);
    assign rx_full  = (rx_level == RX_FULL_LVL);
    assign tx_free  = TX_FULL_LVL - tx_level;

    wmi_thresh_cmp #(.CW(TXLW)) u_tx_cmp (
        .clk    (clk),
        .rst    (rst),
        .count  (tx_free),
        .stages (tx_stages(wm_q.tx_code)),
        .hit    (tx_req)
    );

    wmi_thresh_cmp #(.CW(RXLW)) u_rx_cmp (
        .clk    (clk),
        .rst    (rst),
        .count  (rx_level),
        .stages (rx_stages(wm_q.rx_code)),
        .hit    (rx_req)
    );

    // Event detection
    always_comb begin
        ev.tx_fend = tx_frame_end;
        ev.tx_serr = tx_sync_err;
        ev.tx_ovf  = tx_push & tx_full;
        ev.tx_udf  = tx_pop & tx_empty;
        ev.rx_fend = rx_frame_end;
        ev.rx_serr = rx_sync_err;
        ev.rx_udf  = rx_pop & rx_empty;
        ev.rx_ovf  = rx_push & rx_full;
    end

    always_comb begin
        for (int i = 0; i < N_STICKY; i++)
            clr_v[i] = wr_en && (sel == SEL_CLEAR) && wr_data[sticky_pos(i)];
    end

    wmi_sticky_bank #(.N(N_STICKY)) u_sticky (
        .clk (clk),
        .rst (rst),
        .set (ev),
        .clr (clr_v),
        .q   (sticky_q)
    );

    // Status word assembly
    always_comb begin
        status             = '0;
        status[B_TX_EMPTY] = tx_empty;
        status[B_TX_REQ]   = tx_req;
        status[B_RX_FULL]  = rx_full;
        status[B_RX_REQ]   = rx_req;
        for (int i = 0; i < N_STICKY; i++)
            status[sticky_pos(i)] = sticky_q[i];
    end

    wmi_irq_combine u_irq (
        .clk        (clk),
        .rst        (rst),
        .status     (status),
        .enable     (ier_q),
        .irq        (irq),
        .tx_dma_req (tx_dma_req),
        .rx_dma_req (rx_dma_req)
    );

    // Access qualifiers toward the FIFO control
    assign tx_push_ok = tx_push & ~tx_full;
    assign tx_pop_ok  = tx_pop  & ~tx_empty;
    assign rx_push_ok = rx_push & ~rx_full;
    assign rx_pop_ok  = rx_pop  & ~rx_empty;

    a_r5_push_full_blocked: assert property (@(posedge clk) disable iff (rst)
        (tx_level == TX_FULL_LVL) |-> !tx_push_ok);
    a_r5_pop_empty_blocked: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |-> !rx_pop_ok);
    a_r4_tx_ovf_flag: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_level == TX_FULL_LVL) |=> status[B_TX_OVF]);
    a_r4_rx_udf_flag: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_level == '0) |=> status[B_RX_UDF]);
    a_r13_rsvd_write_inert: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> ($stable(ier_q) && $stable(wm_q)));
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ier_q != '0));

endmodule

// File: tb/wmi_fifo_status_tb.sv
module wmi_fifo_status_tb;

    localparam int TXD = 64;
    localparam int RXD = 256;
    localparam logic [31:0] HELD_M  = 32'h00B8_00B8;
    localparam logic [31:0] KNOWN_M = 32'h30B8_30B8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  tl = '0;
    logic [8:0]  rl = '0;
    logic        tpu = 0, tpo = 0, rpu = 0, rpo = 0;
    logic        tfe = 0, tse = 0, rfe = 0, rse = 0;
    logic        wen = 0;
    logic [1:0]  wsel = '0;
    logic [31:0] wdat = '0;
    logic [31:0] status;
    logic        irq, tdma, rdma, tpu_ok, tpo_ok, rpu_ok, rpo_ok;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int          m_tcode = 0, m_rcode = 0;
    logic [31:0] m_ier = '0;
    logic [31:0] m_held = '0;

    always #4 clk = ~clk;

    wmi_fifo_status u_dut (
        .clk(clk), .rst(rst), .tx_level(tl), .rx_level(rl),
        .tx_push(tpu), .tx_pop(tpo), .rx_push(rpu), .rx_pop(rpo),
        .tx_frame_end(tfe), .tx_sync_err(tse), .rx_frame_end(rfe), .rx_sync_err(rse),
        .wr_en(wen), .wr_sel(wsel), .wr_data(wdat),
        .status(status), .irq(irq), .tx_dma_req(tdma), .rx_dma_req(rdma),
        .tx_push_ok(tpu_ok), .tx_pop_ok(tpo_ok), .rx_push_ok(rpu_ok), .rx_pop_ok(rpo_ok)
    );

    function automatic int tthr(input int c);
        int t [8] = '{64, 32, 24, 16, 12, 8, 4, 1};
        return t[c];
    endfunction

    function automatic int rthr(input int c);
        int t [8] = '{1, 4, 8, 16, 32, 64, 128, 256};
        return t[c];
    endfunction

    task automatic chk(input string req, input string ph, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, ph, $time, act, exp);
        end
    endtask

    task automatic compare(input string ph);
        logic [31:0] e;
        logic        e_irq;
        e = m_held;
        e[29] = (tl == 0);
        e[28] = ((TXD - int'(tl)) >= tthr(m_tcode));
        e[13] = (int'(rl) == RXD);
        e[12] = (int'(rl) >= rthr(m_rcode));
        e_irq = |(e & m_ier & KNOWN_M);
        chk("R1", ph, 32'(status[28]), 32'(e[28]));
        chk("R2", ph, 32'(status[12]), 32'(e[12]));
        chk("R3", ph, {status[29], status[13]}, {e[29], e[13]});
        chk("R4", ph, {status[20], status[19], status[4], status[3]}, {e[20], e[19], e[4], e[3]});
        chk("R6", ph, {status[23], status[21], status[7], status[5]}, {e[23], e[21], e[7], e[5]});
        chk("R12", ph, status & ~KNOWN_M, 32'h0);
        chk("R8", ph, 32'(irq), 32'(e_irq));
        chk("R9", ph, {tdma, rdma}, {m_ier[31] & e[28], m_ier[15] & e[12]});
        chk("R5", ph, {tpu_ok, tpo_ok, rpu_ok, rpo_ok},
            {tpu & (tl != 7'(TXD)), tpo & (tl != 0), rpu & (rl != 9'(RXD)), rpo & (rl != 0)});
    endtask

    task automatic model_update();
        logic [31:0] nx;
        if (rst) begin
            m_tcode = 0; m_rcode = 0; m_ier = '0; m_held = '0;
        end else begin
            nx = m_held;
            if (wen && wsel == 2'd2) nx = nx & ~(wdat & HELD_M);
            if (tfe) nx[23] = 1'b1;
            if (tse) nx[21] = 1'b1;
            if (tpu && tl == 7'(TXD)) nx[20] = 1'b1;
            if (tpo && tl == 0) nx[19] = 1'b1;
            if (rfe) nx[7] = 1'b1;
            if (rse) nx[5] = 1'b1;
            if (rpo && rl == 0) nx[4] = 1'b1;
            if (rpu && rl == 9'(RXD)) nx[3] = 1'b1;
            m_held = nx;
            if (wen && wsel == 2'd0) begin
                m_tcode = int'(wdat[31:29]);
                m_rcode = int'(wdat[15:13]);
            end
            if (wen && wsel == 2'd1) m_ier = wdat;
        end
    endtask

    task automatic tick(input string ph);
        #2;
        compare(ph);
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic quiet();
        tpu = 0; tpo = 0; rpu = 0; rpo = 0;
        tfe = 0; tse = 0; rfe = 0; rse = 0;
        wen = 0; wsel = 2'd0; wdat = '0;
    endtask

    task automatic write(input logic [1:0] s, input logic [31:0] d, input string ph);
        quiet();
        wen = 1; wsel = s; wdat = d;
        tick(ph);
        quiet();
    endtask

    function automatic logic [6:0] pick_tx();
        int r, v;
        r = $urandom_range(0, 4);
        case (r)
            0: v = 0;
            1: v = TXD;
            2, 3: v = TXD - tthr(m_tcode) + int'($urandom_range(0, 1));
            default: v = int'($urandom_range(0, TXD));
        endcase
        if (v > TXD) v = TXD;
        if (v < 0) v = 0;
        return 7'(v);
    endfunction

    function automatic logic [8:0] pick_rx();
        int r, v;
        r = $urandom_range(0, 4);
        case (r)
            0: v = 0;
            1: v = RXD;
            2, 3: v = rthr(m_rcode) - int'($urandom_range(0, 1));
            default: v = int'($urandom_range(0, RXD));
        endcase
        if (v > RXD) v = RXD;
        if (v < 0) v = 0;
        return 9'(v);
    endfunction

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R10: reset state, with full FIFO levels and events applied
        rst = 1; quiet(); tl = 7'(TXD); rl = 9'(RXD); tfe = 1; rpu = 1;
        for (int k = 0; k < 3; k++) tick("R10 reset");
        rst = 0; quiet(); tl = 0; rl = 0;
        tick("R10 after reset");

        // R1: transmit thresholds at and one beside each code
        for (int c = 0; c < 8; c++) begin
            write(2'd0, {3'(c), 29'h0}, "R1 code");
            for (int d = 0; d < 2; d++) begin
                tl = 7'(TXD - tthr(c) + d);
                tick("R1 sweep");
            end
        end
        // R2: receive thresholds at and one beside each code
        for (int c = 0; c < 8; c++) begin
            write(2'd0, {16'h0, 3'(c), 13'h0}, "R2 code");
            for (int d = 1; d >= 0; d--) begin
                rl = 9'(rthr(c) - d);
                tick("R2 sweep");
            end
        end

        // R8/R9: enable everything, then raise each event alone
        write(2'd1, 32'hFFFF_FFFF, "R8 enable all");
        tl = 7'(TXD); rl = 0;
        tpu = 1; tick("R4 push full"); quiet();
        tpo = 1; tl = 0; tick("R5 pop empty tx"); quiet();
        rl = 9'(RXD); rpu = 1; tick("R4 rx push full"); quiet();
        rl = 0; rpo = 1; tick("R4 rx pop empty"); quiet();
        tfe = 1; tse = 1; rfe = 1; rse = 1; tick("R6 pulses"); quiet();
        tick("R6 held");
        // R7: write back what was read
        write(2'd2, status, "R7 write back");
        tick("R7 after clear");
        // R7: clear colliding with its own event
        tfe = 1; wen = 1; wsel = 2'd2; wdat = 32'hFFFF_FFFF; tick("R7 collide"); quiet();
        tick("R7 collide result");
        // R7: partial clear
        rse = 1; tse = 1; tick("R7 set two"); quiet();
        write(2'd2, 32'h0000_0020, "R7 partial");
        tick("R7 partial result");
        // R13: reserved select
        write(2'd3, 32'hFFFF_FFFF, "R13 reserved");
        tick("R13 result");
        // R11: mask everything
        write(2'd1, 32'h0, "R11 mask");
        tl = 0; rl = 9'(RXD); tfe = 1; tick("R11 masked"); quiet();
        tick("R11 masked held");

        // random traffic with boundary-biased levels
        for (int k = 0; k < 4000; k++) begin
            quiet();
            tl = pick_tx(); rl = pick_rx();
            tpu = ($urandom_range(0, 3) == 0); tpo = ($urandom_range(0, 3) == 0);
            rpu = ($urandom_range(0, 3) == 0); rpo = ($urandom_range(0, 3) == 0);
            tfe = ($urandom_range(0, 7) == 0); tse = ($urandom_range(0, 9) == 0);
            rfe = ($urandom_range(0, 7) == 0); rse = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 5) == 0) begin
                wen = 1; wsel = 2'($urandom_range(0, 3));
                wdat = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
            end
            rst = (k == 2000);
            tick(rst ? "R10 mid reset" : "random");
        end
        rst = 0; quiet();
        tick("final");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule